// File: doc/BRIEF.md
# Grouped Lookahead Adder with Rippled Group Carries

This block adds two unsigned operands of configurable width together with a single carry input. It gives a sum of the same width and a carry output. The operand width is split into four-bit slices. Each slice forms its internal carries directly from per-bit generate and propagate terms, using flat sum-of-products equations. No carry inside a slice passes from bit to bit.

Between slices the carry is chained: each slice's carry output drives the next slice's carry input. The carry output of the top slice is the block's carry output. The block has no clock and no state. A parent design can place it in any combinational path and register the result wherever it chooses.

Top module: `blk_cla_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of the arithmetic sum `a_i + b_i + cin_i`, with both operands treated as unsigned.
- R2: `cout_o` equals bit WIDTH of the arithmetic sum `a_i + b_i + cin_i`.
- R3: Within each four-bit slice, every carry formed by the flat lookahead equations equals the carry given by the bit recurrence c[k+1] = g[k] | (p[k] & c[k]), where g is the AND and p is the OR of the two operand bits.
- R4: When both operand bits at the top position of a slice (bit 4j+3) are 1, that slice passes a carry of 1 to the next slice, whatever the lower bits and the slice carry input are.
- R5: With all operand bits of `a_i` set to 1, `b_i` all 0 and `cin_i` = 1, the carry crosses every slice: `sum_o` is all zeros and `cout_o` is 1.
- R6: When both operand bits at the top position of a slice are 0, that slice passes a carry of 0 to the next slice.
- R7: WIDTH must be a positive multiple of 4. The block then holds WIDTH/4 slices and works the same way at WIDTH 8 and at WIDTH 64.
- R8: When both operands and `cin_i` are all zero, `sum_o` and `cout_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| cin_i | input | 1 | Carry into the lowest slice |
| sum_o | output | WIDTH | Sum, modulo 2^WIDTH |
| cout_o | output | 1 | Carry out of the highest slice |

## Verification
Whenever the inputs settle, the embedded assertions compare the flat per-slice carries against the bit recurrence. They also check the forced carry for a generating or killing top bit, and compare the full result against a behavioural addition. The bench adds the scenarios that the assertions cannot choose for themselves. These are every operand and carry combination at width 8, a carry that has to travel through all sixteen slices at width 64, and random wide operands. Each result is compared through the scoreboard against an independently computed sum.

// File: rtl/blk_cla_pkg.sv
package blk_cla_pkg;
    localparam int unsigned SLICE_W = 4;

    typedef struct packed {
        logic [SLICE_W-1:0] sum;
        logic               cout;
    } slice_res_t;
endpackage

// File: rtl/blk_cla_gp.sv
module blk_cla_gp #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prop_o
);
    for (genvar k = 0; k < W; k++) begin : g_bit
        assign gen_o[k]  = x_i[k] & y_i[k];
        assign prop_o[k] = x_i[k] | y_i[k];
    end
endmodule

// File: rtl/blk_cla_slice.sv
module blk_cla_slice
    import blk_cla_pkg::*;
(
    input  logic [SLICE_W-1:0] x_i,
    input  logic [SLICE_W-1:0] y_i,
    input  logic               c_i,
    output logic [SLICE_W-1:0] s_o,
    output logic               c_o
);
    logic [SLICE_W-1:0] gen_w;
    logic [SLICE_W-1:0] prop_w;
    logic [SLICE_W:0]   car_d;
    slice_res_t         res_d;

    blk_cla_gp #(.W(SLICE_W)) u_gp (
        .x_i   (x_i),
        .y_i   (y_i),
        .gen_o (gen_w),
        .prop_o(prop_w)
    );

    // Flat two-level carries: each carry is an OR of AND products.
    always_comb begin
        car_d[0] = c_i;
        for (int k = 1; k <= SLICE_W; k++) begin
            logic acc;
            logic term;
            term = c_i;
            for (int m = 0; m < k; m++) term = term & prop_w[m];
            acc = term;
            for (int j = 0; j < k; j++) begin
                logic prod;
                prod = gen_w[j];
                for (int m = j + 1; m < k; m++) prod = prod & prop_w[m];
                acc = acc | prod;
            end
            car_d[k] = acc;
        end
        res_d.sum  = x_i ^ y_i ^ car_d[SLICE_W-1:0];
        res_d.cout = car_d[SLICE_W];
    end

    assign s_o = res_d.sum;
    assign c_o = res_d.cout;

    always_comb begin
        for (int k = 0; k < SLICE_W; k++) begin
            a_r3_recurrence: assert (car_d[k+1] == (gen_w[k] | (prop_w[k] & car_d[k])))
                else $error("R3 flat carry %0d disagrees with recurrence", k + 1);
        end
        if (x_i[SLICE_W-1] & y_i[SLICE_W-1]) begin
            a_r4_top_generate: assert (c_o == 1'b1)
                else $error("R4 generating top bit did not force carry");
        end
        if (!(x_i[SLICE_W-1] | y_i[SLICE_W-1])) begin
            a_r6_top_kill: assert (c_o == 1'b0)
                else $error("R6 killing top bit did not clear carry");
        end
    end
endmodule

// File: rtl/blk_cla_adder.sv
module blk_cla_adder
    import blk_cla_pkg::*;
#(
    parameter int unsigned WIDTH = 64
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int unsigned NSLICE = WIDTH / SLICE_W;

    // R7: width must split evenly into slices
    if ((WIDTH % SLICE_W) != 0 || WIDTH == 0) begin : g_bad_width
        $error("WIDTH must be a positive multiple of the slice width");
    end

    logic [NSLICE:0] chain_d;
    logic [WIDTH:0]  ref_d;

    assign chain_d[0] = cin_i;

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        blk_cla_slice u_slice (
            .x_i(a_i[s*SLICE_W +: SLICE_W]),
            .y_i(b_i[s*SLICE_W +: SLICE_W]),
            .c_i(chain_d[s]),
            .s_o(sum_o[s*SLICE_W +: SLICE_W]),
            .c_o(chain_d[s+1])
        );
    end

    assign cout_o = chain_d[NSLICE];

    always_comb begin
        ref_d = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
        a_r1_sum_matches: assert (sum_o == ref_d[WIDTH-1:0])
            else $error("R1 sum mismatch");
        a_r2_carry_matches: assert (cout_o == ref_d[WIDTH])
            else $error("R2 carry-out mismatch");
    end
endmodule

// File: tb/tb_blk_cla_adder.sv
module tb_blk_cla_adder;
    typedef struct {
        logic        narrow;
        logic [63:0] a;
        logic [63:0] b;
        logic        ci;
        logic [64:0] exp;
        string       req;
    } item_t;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [63:0] a64 = '0, b64 = '0;
    logic        c64 = 1'b0;
    logic [63:0] s64;
    logic        co64;
    logic [7:0]  a8 = '0, b8 = '0;
    logic        c8 = 1'b0;
    logic [7:0]  s8;
    logic        co8;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit drv_done = 1'b0;
    item_t q[$];

    blk_cla_adder #(.WIDTH(64)) dut (
        .a_i(a64), .b_i(b64), .cin_i(c64), .sum_o(s64), .cout_o(co64)
    );
    blk_cla_adder #(.WIDTH(8)) dut_w8 (
        .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8), .cout_o(co8)
    );

    task automatic drive(input logic narrow, input logic [63:0] a,
                         input logic [63:0] b, input logic ci, input string req);
        item_t it;
        @(posedge clk);
        it.narrow = narrow;
        it.a = a; it.b = b; it.ci = ci; it.req = req;
        if (narrow) begin
            a8 = a[7:0]; b8 = b[7:0]; c8 = ci;
            it.exp = {57'd0, ({1'b0, a[7:0]} + {1'b0, b[7:0]} + {8'd0, ci})};
        end else begin
            a64 = a; b64 = b; c64 = ci;
            it.exp = {1'b0, a} + {1'b0, b} + {64'd0, ci};
        end
        q.push_back(it);
    endtask

    // Monitor: compares at the falling edge, away from driving edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [64:0] got;
            it = q.pop_front();
            got = it.narrow ? {56'd0, co8, s8} : {co64, s64};
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s a=%h b=%h ci=%0d got=%h exp=%h",
                         it.req, it.a, it.b, it.ci, got, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !drv_done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R8: all-zero inputs give all-zero outputs (both widths)
        drive(1'b0, 64'd0, 64'd0, 1'b0, "R8");
        drive(1'b1, 64'd0, 64'd0, 1'b0, "R8");
        // R5: carry through every slice
        drive(1'b0, {64{1'b1}}, 64'd0, 1'b1, "R5");
        drive(1'b0, {64{1'b1}}, {64{1'b1}}, 1'b1, "R2");
        // R4: both top bits of slice 0 set, rest of operands zero
        drive(1'b0, 64'h8, 64'h8, 1'b0, "R4");
        drive(1'b0, 64'h0000_0000_0000_00F8, 64'h0000_0000_0000_0008, 1'b1, "R4");
        // R6: top bits of slice 0 clear, lower bits all generating
        drive(1'b0, 64'h7, 64'h7, 1'b1, "R6");
        drive(1'b0, 64'hFFFF_FFFF_FFFF_FFF7, 64'h0000_0000_0000_0007, 1'b1, "R6");
        // R3: alternating patterns stress each in-slice position
        drive(1'b0, 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, "R3");
        drive(1'b0, 64'h7777_7777_7777_7777, 64'h1111_1111_1111_1111, 1'b0, "R3");
        // R7 and R1/R2: exhaustive at width 8
        for (int ci = 0; ci < 2; ci++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    drive(1'b1, 64'(a), 64'(b), ci[0], "R7");
        // R1/R2: random wide operands
        for (int n = 0; n < 2000; n++)
            drive(1'b0, {$urandom(), $urandom()}, {$urandom(), $urandom()},
                  $urandom() & 1, "R1");
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        drv_done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule